// File: doc/BRIEF.md
# Power Domain Sequencing Controller

This block switches a set of independent power domains on and off under software control. Each domain has its own 0x80-byte register window. Domain N starts at offset 0x80*N from the block's base address. Within a window, software writes a target state to a command register. A hardware sequencer then steps the domain's four control outputs through a fixed order: the power switch, the output isolation gate, the clock enable and the active-low reset. A programmed number of controller clock cycles separates the steps.

Software polls a status register. It reports the state the domain last reached, a busy bit and a sticky completion flag, which is cleared by writing a one to it. Two read-only registers mirror the control outputs. For bring-up, software can also drive the four outputs directly when a manual-mode bit is set.

The sequencer has nine states:

- `S_IDLE`: waiting for a command.
- Power-down path:
  - `S_OFF_ISO`: isolate the outputs.
  - `S_OFF_CLK`: stop the clock.
  - `S_OFF_RST`: assert reset.
  - `S_OFF_PWR`: open the switch.
- Power-up path:
  - `S_ON_PWR`: close the switch.
  - `S_ON_ISO`: drop isolation.
  - `S_ON_CLK`: start the clock.
  - `S_ON_RST`: release reset.

The transitions are:

- From `S_IDLE`, a command that differs from the current state starts the first state of the matching path.
- Each step state moves to the next state of its path when its down-counter reaches zero.
- `S_OFF_PWR` and `S_ON_RST` return to `S_IDLE`. This return records the new state and sets the completion flag.

Each step state is entered with its delay loaded into the counter, so it lasts delay+1 cycles.

Top module: `pwr_dom_seq`

## Requirements

- R1: After reset every domain has switch on, isolation off, clock on and reset released. Its status register (offset 0x24) reads 0x0001_0000: bits 17:16 hold the state (1 = on, 2 = off), bit 3 is busy and bit 1 is complete.
- R2: Writing exactly 2 to the command register (0x20) of an idle, powered domain produces the power-down timing, with d the off-delay register (0x18):
  - isolation is asserted on the write edge;
  - the clock stops d+1 cycles later;
  - reset asserts 2(d+1) cycles after the write;
  - the switch opens 3(d+1) cycles after the write;
  - one cycle after the switch opens, the state reads 2 and complete is set.
- R3: Writing exactly 1 to the command register of an idle, off domain produces the power-up timing, with s the switch delay (0x14) and o the on delay (0x1C):
  - the switch closes on the write edge;
  - isolation drops s+1 cycles later;
  - the clock starts at s+2;
  - reset releases at s+o+3;
  - at s+o+4 the state reads 1 and complete is set.
- R4: Busy (status bit 3) is 1 from the write edge of an accepted command until the cycle the sequence completes, and 0 otherwise.
- R5: The complete flag stays set until a status write with bit 1 = 1 clears it. A status write with bit 1 = 0 leaves it set.
- R6: A command written while busy is ignored. A command value other than exactly 1 or 2 is ignored.
- R7: A command equal to the current state sets complete on its write edge, leaves busy at 0 and leaves every output unchanged.
- R8: A delay register value of 0 makes the corresponding step last one cycle.
- R9: The gate status register (0x30) reads bit 0 = reset-n output, bit 1 = clock enable and bit 2 = isolation. The switch status register (0x34) bit 0 reads the switch output.
- R10: With active-control register (0x2C) bit 0 = 1, bit 0 of a write drives an output directly:
  - a write to 0x00 drives reset-n;
  - a write to 0x04 drives the clock enable;
  - a write to 0x08 drives isolation;
  - a write with bit 0 = 1 to 0x0C closes the switch;
  - a write with bit 0 = 1 to 0x10 opens it.

  With 0x2C bit 0 = 0, these writes have no effect.
- R11: A write reaches only the domain whose window contains the address. A read beyond the last domain returns 0.
- R12: The delay registers 0x14, 0x18 and 0x1C hold the full 32-bit written value and reset to 2.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 9 | Byte address: window index in the upper bits, register offset in bits 6:0 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| dom_pwr_en | output | 3 | Per-domain power switch enable |
| dom_iso | output | 3 | Per-domain output isolation (1 = isolated) |
| dom_clk_en | output | 3 | Per-domain clock enable |
| dom_rst_n | output | 3 | Per-domain active-low reset |

## Verification

The hardest case to reach is a command arriving mid-sequence. It must land while the step counter is running and neither at the start nor at the end of a path. The bench reaches it by programming an off delay of 4, then writing the opposite command three cycles into the power-down. It then confirms that the power-down still finishes on its original cycle. Each timing check steps cycle by cycle from the write edge. At every cycle it compares all four outputs and the status register against values computed from the delays.

// File: rtl/pwr_dom_pkg.sv
package pwr_dom_pkg;

    // Sequencer states; power-down path then power-up path.
    typedef enum logic [3:0] {
        S_IDLE,
        S_OFF_ISO,
        S_OFF_CLK,
        S_OFF_RST,
        S_OFF_PWR,
        S_ON_PWR,
        S_ON_ISO,
        S_ON_CLK,
        S_ON_RST
    } seq_state_t;

    // Domain state encoding shared by the command and status registers.
    localparam logic [1:0] PD_ON  = 2'd1;
    localparam logic [1:0] PD_OFF = 2'd2;

    // Register offsets within one domain window.
    localparam logic [6:0] OFS_RSTN   = 7'h00;
    localparam logic [6:0] OFS_CLK    = 7'h04;
    localparam logic [6:0] OFS_ISO    = 7'h08;
    localparam logic [6:0] OFS_SW_ON  = 7'h0C;
    localparam logic [6:0] OFS_SW_OFF = 7'h10;
    localparam logic [6:0] OFS_DLY_SW = 7'h14;
    localparam logic [6:0] OFS_DLY_DN = 7'h18;
    localparam logic [6:0] OFS_DLY_UP = 7'h1C;
    localparam logic [6:0] OFS_CMD    = 7'h20;
    localparam logic [6:0] OFS_STAT   = 7'h24;
    localparam logic [6:0] OFS_MANUAL = 7'h2C;
    localparam logic [6:0] OFS_GATES  = 7'h30;
    localparam logic [6:0] OFS_SWSTAT = 7'h34;

    // Status register bit positions.
    localparam int STAT_DONE_BIT  = 1;
    localparam int STAT_BUSY_BIT  = 3;
    localparam int STAT_STATE_LSB = 16;

endpackage

// File: rtl/pwr_dom_regs.sv
module pwr_dom_regs
    import pwr_dom_pkg::*;
#(
    parameter int DW      = 32,
    parameter int DLY_RST = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [6:0]    ofs,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    // state reported by the sequencer
    input  logic          rst_q,
    input  logic          clk_q,
    input  logic          iso_q,
    input  logic          pwr_q,
    input  logic          busy,
    input  logic          done,
    input  logic [1:0]    cur_state,
    // to the sequencer
    output logic [DW-1:0] dly_sw,
    output logic [DW-1:0] dly_dn,
    output logic [DW-1:0] dly_up,
    output logic          cmd_stb,
    output logic [1:0]    cmd_tgt,
    output logic          done_clr,
    output logic          man_rst_we,
    output logic          man_clk_we,
    output logic          man_iso_we,
    output logic          man_pwr_set,
    output logic          man_pwr_clr,
    output logic          man_val
);

    logic man_q;

    // Delay and manual-mode storage.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dly_sw <= DW'(DLY_RST);
            dly_dn <= DW'(DLY_RST);
            dly_up <= DW'(DLY_RST);
            man_q  <= 1'b0;
        end else if (we) begin
            if (ofs == OFS_DLY_SW) dly_sw <= wdata;
            if (ofs == OFS_DLY_DN) dly_dn <= wdata;
            if (ofs == OFS_DLY_UP) dly_up <= wdata;
            if (ofs == OFS_MANUAL) man_q  <= wdata[0];
        end
    end

    // Strobes decoded from a write; the command must match a code exactly.
    always_comb begin
        cmd_stb     = we && (ofs == OFS_CMD) &&
                      ((wdata == DW'(PD_ON)) || (wdata == DW'(PD_OFF)));
        cmd_tgt     = wdata[1:0];
        done_clr    = we && (ofs == OFS_STAT) && wdata[STAT_DONE_BIT];
        man_val     = wdata[0];
        man_rst_we  = we && man_q && (ofs == OFS_RSTN);
        man_clk_we  = we && man_q && (ofs == OFS_CLK);
        man_iso_we  = we && man_q && (ofs == OFS_ISO);
        man_pwr_set = we && man_q && (ofs == OFS_SW_ON)  && wdata[0];
        man_pwr_clr = we && man_q && (ofs == OFS_SW_OFF) && wdata[0];
    end

    // Read multiplexer.
    always_comb begin
        rdata = '0;
        unique case (ofs)
            OFS_RSTN:   rdata[0] = rst_q;
            OFS_CLK:    rdata[0] = clk_q;
            OFS_ISO:    rdata[0] = iso_q;
            OFS_SW_ON:  rdata[0] = pwr_q;
            OFS_SW_OFF: rdata[0] = ~pwr_q;
            OFS_DLY_SW: rdata    = dly_sw;
            OFS_DLY_DN: rdata    = dly_dn;
            OFS_DLY_UP: rdata    = dly_up;
            OFS_STAT: begin
                rdata[STAT_STATE_LSB +: 2] = cur_state;
                rdata[STAT_BUSY_BIT]       = busy;
                rdata[STAT_DONE_BIT]       = done;
            end
            OFS_MANUAL: rdata[0] = man_q;
            OFS_GATES:  rdata[2:0] = {iso_q, clk_q, rst_q};
            OFS_SWSTAT: rdata[0] = pwr_q;
            default:    rdata = '0;
        endcase
    end

    // A command strobe only ever comes from a write cycle.
    p_cmd_from_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |-> (we && (cmd_tgt == PD_ON || cmd_tgt == PD_OFF)));

    // Delay storage changes only when its own offset is written.
    p_dly_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && ofs == OFS_DLY_DN) |=> $stable(dly_dn));

endmodule

// File: rtl/pwr_dom_fsm.sv
module pwr_dom_fsm
    import pwr_dom_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] dly_sw,
    input  logic [DW-1:0] dly_dn,
    input  logic [DW-1:0] dly_up,
    input  logic          cmd_stb,
    input  logic [1:0]    cmd_tgt,
    input  logic          done_clr,
    input  logic          man_rst_we,
    input  logic          man_clk_we,
    input  logic          man_iso_we,
    input  logic          man_pwr_set,
    input  logic          man_pwr_clr,
    input  logic          man_val,
    output logic          rst_q,
    output logic          clk_q,
    output logic          iso_q,
    output logic          pwr_q,
    output logic          busy,
    output logic          done,
    output logic [1:0]    cur_state
);

    seq_state_t    state_q, state_d;
    logic [DW-1:0] cnt_q;
    logic [DW-1:0] ld_val;
    logic          step_end;
    logic          same_hit;
    logic          leave_seq;

    assign busy      = (state_q != S_IDLE);
    assign step_end  = (cnt_q == '0);
    assign same_hit  = (state_q == S_IDLE) && cmd_stb && (cmd_tgt == cur_state);
    assign leave_seq = busy && (state_d == S_IDLE);

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (cmd_stb && (cmd_tgt != cur_state))
                    state_d = (cmd_tgt == PD_OFF) ? S_OFF_ISO : S_ON_PWR;
            end
            S_OFF_ISO: if (step_end) state_d = S_OFF_CLK;
            S_OFF_CLK: if (step_end) state_d = S_OFF_RST;
            S_OFF_RST: if (step_end) state_d = S_OFF_PWR;
            S_OFF_PWR: if (step_end) state_d = S_IDLE;
            S_ON_PWR:  if (step_end) state_d = S_ON_ISO;
            S_ON_ISO:  if (step_end) state_d = S_ON_CLK;
            S_ON_CLK:  if (step_end) state_d = S_ON_RST;
            S_ON_RST:  if (step_end) state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // Dwell loaded on entry to each state.
    always_comb begin
        unique case (state_d)
            S_OFF_ISO, S_OFF_CLK, S_OFF_RST: ld_val = dly_dn;
            S_ON_PWR:                        ld_val = dly_sw;
            S_ON_CLK:                        ld_val = dly_up;
            default:                         ld_val = '0;
        endcase
    end

    // State register and step counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q)
                cnt_q <= ld_val;
            else if (!step_end)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    // Control outputs, reported state and completion flag.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_q     <= 1'b1;
            clk_q     <= 1'b1;
            iso_q     <= 1'b0;
            pwr_q     <= 1'b1;
            cur_state <= PD_ON;
            done      <= 1'b0;
        end else begin
            if (state_d != state_q) begin
                unique case (state_d)
                    S_OFF_ISO: iso_q <= 1'b1;
                    S_OFF_CLK: clk_q <= 1'b0;
                    S_OFF_RST: rst_q <= 1'b0;
                    S_OFF_PWR: pwr_q <= 1'b0;
                    S_ON_PWR:  pwr_q <= 1'b1;
                    S_ON_ISO:  iso_q <= 1'b0;
                    S_ON_CLK:  clk_q <= 1'b1;
                    S_ON_RST:  rst_q <= 1'b1;
                    S_IDLE:    cur_state <= (state_q == S_OFF_PWR) ? PD_OFF : PD_ON;
                    default:   ;
                endcase
            end else if (state_q == S_IDLE) begin
                if (man_rst_we) rst_q <= man_val;
                if (man_clk_we) clk_q <= man_val;
                if (man_iso_we) iso_q <= man_val;
                if (man_pwr_set) pwr_q <= 1'b1;
                else if (man_pwr_clr) pwr_q <= 1'b0;
            end
            if (leave_seq || same_hit)
                done <= 1'b1;
            else if (done_clr)
                done <= 1'b0;
        end
    end

    // The switch opens only after the domain is isolated, stopped and held.
    p_order_dn_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_OFF_PWR) |-> (iso_q && !clk_q && !rst_q && !pwr_q));

    // Reset releases only into a powered, clocked, unisolated domain.
    p_order_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rst_q) && $past(state_q) == S_ON_CLK) |-> (pwr_q && clk_q && !iso_q));

    // A sequence that ends leaves the completion flag set.
    p_done_on_finish_r5: assert property (@(posedge clk) disable iff (!rst_n)
        leave_seq |=> (done && !busy));

    // A command in mid-step never disturbs the running state.
    p_busy_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb && busy && !step_end) |=> (state_q == $past(state_q)));

    // Same-state command completes without sequencing.
    p_same_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
        same_hit |=> (done && state_q == S_IDLE));

    // While a step holds, the counter falls by exactly one per cycle.
    p_cnt_dec_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && state_q == $past(state_q)) |-> (cnt_q == $past(cnt_q) - 1'b1));

    // Manual writes never move outputs while sequencing.
    p_manual_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && state_d == state_q && (man_clk_we || man_iso_we)) |=> $stable({clk_q, iso_q}));

endmodule

// File: rtl/pwr_dom_slice.sv
module pwr_dom_slice
    import pwr_dom_pkg::*;
#(
    parameter int DW      = 32,
    parameter int DLY_RST = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [6:0]    ofs,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          pwr_en,
    output logic          iso,
    output logic          clk_en,
    output logic          rst_out_n
);

    logic [DW-1:0] dly_sw, dly_dn, dly_up;
    logic          cmd_stb, done_clr;
    logic [1:0]    cmd_tgt, cur_state;
    logic          man_rst_we, man_clk_we, man_iso_we;
    logic          man_pwr_set, man_pwr_clr, man_val;
    logic          busy, done;

    pwr_dom_regs #(.DW(DW), .DLY_RST(DLY_RST)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .we          (we),
        .ofs         (ofs),
        .wdata       (wdata),
        .rdata       (rdata),
        .rst_q       (rst_out_n),
        .clk_q       (clk_en),
        .iso_q       (iso),
        .pwr_q       (pwr_en),
        .busy        (busy),
        .done        (done),
        .cur_state   (cur_state),
        .dly_sw      (dly_sw),
        .dly_dn      (dly_dn),
        .dly_up      (dly_up),
        .cmd_stb     (cmd_stb),
        .cmd_tgt     (cmd_tgt),
        .done_clr    (done_clr),
        .man_rst_we  (man_rst_we),
        .man_clk_we  (man_clk_we),
        .man_iso_we  (man_iso_we),
        .man_pwr_set (man_pwr_set),
        .man_pwr_clr (man_pwr_clr),
        .man_val     (man_val)
    );

    pwr_dom_fsm #(.DW(DW)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .dly_sw      (dly_sw),
        .dly_dn      (dly_dn),
        .dly_up      (dly_up),
        .cmd_stb     (cmd_stb),
        .cmd_tgt     (cmd_tgt),
        .done_clr    (done_clr),
        .man_rst_we  (man_rst_we),
        .man_clk_we  (man_clk_we),
        .man_iso_we  (man_iso_we),
        .man_pwr_set (man_pwr_set),
        .man_pwr_clr (man_pwr_clr),
        .man_val     (man_val),
        .rst_q       (rst_out_n),
        .clk_q       (clk_en),
        .iso_q       (iso),
        .pwr_q       (pwr_en),
        .busy        (busy),
        .done        (done),
        .cur_state   (cur_state)
    );

endmodule

// File: rtl/pwr_dom_seq.sv
module pwr_dom_seq #(
    parameter int NUM_DOM = 3,
    parameter int DW      = 32,
    parameter int DLY_RST = 2,
    localparam int IDX_W  = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1,
    localparam int AW     = 7 + IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we,
    input  logic [AW-1:0]      bus_addr,
    input  logic [DW-1:0]      bus_wdata,
    output logic [DW-1:0]      bus_rdata,
    output logic [NUM_DOM-1:0] dom_pwr_en,
    output logic [NUM_DOM-1:0] dom_iso,
    output logic [NUM_DOM-1:0] dom_clk_en,
    output logic [NUM_DOM-1:0] dom_rst_n
);

    logic [IDX_W-1:0] win_idx;
    logic [6:0]       win_ofs;
    logic [DW-1:0]    slice_rd [NUM_DOM];

    assign win_idx = bus_addr[AW-1:7];
    assign win_ofs = bus_addr[6:0];

    for (genvar g = 0; g < NUM_DOM; g++) begin : g_dom
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
        pwr_dom_slice #(.DW(DW), .DLY_RST(DLY_RST)) u_slice (
            .clk       (clk),
            .rst_n     (rst_n),
            .we        (bus_we && (win_idx == MY_IDX)),
            .ofs       (win_ofs),
            .wdata     (bus_wdata),
            .rdata     (slice_rd[g]),
            .pwr_en    (dom_pwr_en[g]),
            .iso       (dom_iso[g]),
            .clk_en    (dom_clk_en[g]),
            .rst_out_n (dom_rst_n[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int j = 0; j < NUM_DOM; j++)
            if (win_idx == IDX_W'(j)) bus_rdata = slice_rd[j];
    end

    // A domain's outputs never change in a cycle with no write to its window
    // unless it is already sequencing (checked for domain 0).
    p_window_isolation_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && win_idx != '0 && !g_dom[0].u_slice.busy && !g_dom[0].u_slice.u_fsm.done_clr)
        |=> $stable({dom_pwr_en[0], dom_iso[0], dom_clk_en[0], dom_rst_n[0]}));

endmodule

// File: tb/pwr_dom_seq_bench.sv
module pwr_dom_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  dom_pwr_en, dom_iso, dom_clk_en, dom_rst_n;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;   // 50 MHz

    pwr_dom_seq u_pwr_dom_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .dom_pwr_en (dom_pwr_en),
        .dom_iso    (dom_iso),
        .dom_clk_en (dom_clk_en),
        .dom_rst_n  (dom_rst_n)
    );

    // {we, addr, data, expected read}
    localparam int NV = 12;
    localparam logic [73:0] VEC [NV] = '{
        {1'b0, 9'h024, 32'h0,        32'h0001_0000}, // R1 status after reset
        {1'b0, 9'h000, 32'h0,        32'h0000_0001}, // R1 reset-n released
        {1'b0, 9'h030, 32'h0,        32'h0000_0003}, // R9 gates: rst 1, clk 1, iso 0
        {1'b0, 9'h034, 32'h0,        32'h0000_0001}, // R9 switch closed
        {1'b0, 9'h014, 32'h0,        32'h0000_0002}, // R12 delay reset value
        {1'b1, 9'h014, 32'h5,        32'h0},
        {1'b0, 9'h014, 32'h0,        32'h0000_0005}, // R12 readback
        {1'b1, 9'h11C, 32'hFFFF_FFFF, 32'h0},
        {1'b0, 9'h11C, 32'h0,        32'hFFFF_FFFF}, // R12 full width, domain 2
        {1'b0, 9'h01C, 32'h0,        32'h0000_0002}, // R11 domain 0 untouched
        {1'b0, 9'h0A4, 32'h0,        32'h0001_0000}, // R11 domain 1 status
        {1'b0, 9'h180, 32'h0,        32'h0}          // R11 unmapped window
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // Compare domain outputs {pwr, iso, clk, rst_n} and status register.
    task automatic chk_dom(input int dm, input logic [3:0] exp_o, input logic [31:0] exp_s, input string tag);
        logic [31:0] s;
        logic [3:0]  o;
        o = {dom_pwr_en[dm], dom_iso[dm], dom_clk_en[dm], dom_rst_n[dm]};
        chk(o == exp_o, {tag, " outputs"}, 32'(o), 32'(exp_o));
        rd(9'(dm * 128 + 32'h24), s);
        chk(s == exp_s, {tag, " status"}, s, exp_s);
    endtask

    function automatic logic [31:0] stat(input logic [1:0] st, input bit bsy, input bit dn);
        return {14'd0, st, 12'd0, bsy, 1'b0, dn, 1'b0};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Table-driven register checks
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][73]) wr(VEC[i][72:64], VEC[i][63:32]);
            else begin
                rd(VEC[i][72:64], r);
                chk(r == VEC[i][31:0], $sformatf("R1/R9/R11/R12 vector %0d", i), r, VEC[i][31:0]);
            end
        end

        // R2 / R4: power-down with off delay 2
        wr(9'h018, 32'd2);
        wr(9'h020, 32'd2);
        for (int k = 0; k <= 10; k++) begin
            logic [3:0] eo;
            eo = {k < 9, 1'b1, k < 3, k < 6};
            chk_dom(0, eo, (k >= 10) ? stat(2'd2, 0, 1) : stat(2'd1, 1, 0), $sformatf("R2 R4 down k=%0d", k));
            @(negedge clk);
        end

        // R5: write of 0 keeps the flag, bit 1 clears it
        wr(9'h024, 32'h0);
        chk_dom(0, 4'b0100, stat(2'd2, 0, 1), "R5 keep");
        wr(9'h024, 32'h2);
        chk_dom(0, 4'b0100, stat(2'd2, 0, 0), "R5 clear");

        // R3 / R4: power-up with switch delay 1, on delay 3
        wr(9'h014, 32'd1);
        wr(9'h01C, 32'd3);
        wr(9'h020, 32'd1);
        for (int k = 0; k <= 8; k++) begin
            logic [3:0] eo;
            eo = {1'b1, k < 2, k >= 3, k >= 7};
            chk_dom(0, eo, (k >= 8) ? stat(2'd1, 0, 1) : stat(2'd2, 1, 0), $sformatf("R3 R4 up k=%0d", k));
            @(negedge clk);
        end

        // R7: same-state command
        wr(9'h024, 32'h2);
        wr(9'h020, 32'd1);
        chk_dom(0, 4'b1011, stat(2'd1, 0, 1), "R7 same state");
        @(negedge clk);
        chk_dom(0, 4'b1011, stat(2'd1, 0, 1), "R7 no sequencing");
        wr(9'h024, 32'h2);

        // R8: zero delays
        wr(9'h018, 32'd0);
        wr(9'h020, 32'd2);
        for (int k = 0; k <= 4; k++) begin
            chk_dom(0, {k < 3, 1'b1, k < 1, k < 2},
                    (k >= 4) ? stat(2'd2, 0, 1) : stat(2'd1, 1, 0), $sformatf("R8 down k=%0d", k));
            @(negedge clk);
        end
        wr(9'h014, 32'd0);
        wr(9'h01C, 32'd0);
        wr(9'h024, 32'h2);
        wr(9'h020, 32'd1);
        for (int k = 0; k <= 4; k++) begin
            chk_dom(0, {1'b1, k < 1, k >= 2, k >= 3},
                    (k >= 4) ? stat(2'd1, 0, 1) : stat(2'd2, 1, 0), $sformatf("R8 up k=%0d", k));
            @(negedge clk);
        end

        // R6: command while busy, then invalid codes
        wr(9'h024, 32'h2);
        wr(9'h018, 32'd4);
        wr(9'h020, 32'd2);
        repeat (2) @(negedge clk);
        wr(9'h020, 32'd1);                       // k=3, mid-step
        chk_dom(0, 4'b1111, stat(2'd1, 1, 0), "R6 busy command");
        repeat (12) @(negedge clk);              // k=15: switch open, not yet done
        chk_dom(0, 4'b0100, stat(2'd1, 1, 0), "R6 path kept");
        @(negedge clk);                          // k=16
        chk_dom(0, 4'b0100, stat(2'd2, 0, 1), "R6 finished off");
        wr(9'h024, 32'h2);
        wr(9'h020, 32'd3);
        repeat (2) @(negedge clk);
        chk_dom(0, 4'b0100, stat(2'd2, 0, 0), "R6 code 3");
        wr(9'h020, 32'd0);
        wr(9'h020, 32'h0000_0101);
        repeat (2) @(negedge clk);
        chk_dom(0, 4'b0100, stat(2'd2, 0, 0), "R6 code 0 and wide value");

        // R10: manual drive
        wr(9'h02C, 32'd1);
        wr(9'h00C, 32'd1);
        chk(dom_pwr_en[0] == 1'b1, "R10 switch on", 32'(dom_pwr_en[0]), 32'd1);
        wr(9'h008, 32'd0);
        wr(9'h004, 32'd1);
        wr(9'h000, 32'd1);
        rd(9'h030, r);
        chk(r == 32'd3, "R10 R9 gate status", r, 32'd3);
        wr(9'h010, 32'd1);
        rd(9'h034, r);
        chk(r == 32'd0, "R10 R9 switch off", r, 32'd0);
        wr(9'h02C, 32'd0);
        wr(9'h00C, 32'd1);
        wr(9'h004, 32'd0);
        chk({dom_pwr_en[0], dom_clk_en[0]} == 2'b01, "R10 ignored in auto",
            32'({dom_pwr_en[0], dom_clk_en[0]}), 32'd1);

        // R11: domain 1 powers down alone (off delay 2 from reset)
        wr(9'h0A0, 32'd2);
        chk({dom_iso[1], dom_iso[2]} == 2'b10, "R11 only domain 1 isolates",
            32'({dom_iso[1], dom_iso[2]}), 32'd2);
        repeat (10) @(negedge clk);
        chk_dom(1, 4'b0100, stat(2'd2, 0, 1), "R11 domain 1 off");
        chk_dom(2, 4'b1011, stat(2'd1, 0, 0), "R11 domain 2 on");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule